// File: doc/BRIEF.md
# Data Bus Address Splitter

This block sits between a processor's single data bus and two downstream targets: a combined instruction and data memory, and an external port for peripherals and accelerators. Each strobed access is steered by the top two bits of its address. The lowest quarter of the address space goes to memory, and everything else goes to the external port. Read data and the acknowledge are returned from whichever target was chosen. That choice is held until the access completes.

A parameter turns on a simulation aid. When it is set, writes to two fixed addresses never leave the block. A write to the log address hands the low data byte to the testbench as a one-cycle character pulse. A write to the halt address raises a sticky end-of-simulation flag. Both writes are acknowledged locally one clock later. With the parameter cleared, those addresses are ordinary external accesses.

Top module: `dbus_splitter`

## Requirements
- R1: A strobed access whose address bits [31:30] equal 2'b00 raises `mem_stb` only; `ext_stb` stays low.
- R2: A strobed access with address bits [31:30] not equal to 2'b00 raises `ext_stb` only, unless R6 or R7 claims it.
- R3: Address, write data, byte select and write enable from the host appear unchanged on both downstream ports in every cycle.
- R4: `hst_rdt` and `hst_ack` come from the selected port only; an acknowledge or read data on the other port has no effect.
- R5: Once an access has started, its target is held until the acknowledge, even if the host address moves into another region meanwhile.
- R6: With `SIM_EN=1`, a write to 0x8000_0000 strobes neither port, is acknowledged in the cycle after the strobe first appears, and drives `log_valid` high for exactly that one cycle with `log_char` equal to data bits [7:0].
- R7: With `SIM_EN=1`, a write to 0x9000_0000 strobes neither port, is acknowledged in the next cycle, and sets `sim_done`, which then stays high until reset.
- R8: With `SIM_EN=0`, writes to 0x8000_0000 and 0x9000_0000 go to the external port, and `log_valid` and `sim_done` stay low.
- R9: With `SIM_EN=1`, reads from either special address go to the external port and do not touch `log_valid` or `sim_done`.
- R10: While reset is asserted with no strobe, both port strobes, `hst_ack`, `log_valid` and `sim_done` are low.
- R11: Exactly one acknowledge reaches the host per access, and `hst_ack` is never high without `hst_stb`. A zero-latency target acknowledge passes through in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hst_adr | input | 32 | Host address |
| hst_dat | input | 32 | Host write data |
| hst_sel | input | 4 | Host byte select |
| hst_we | input | 1 | Host write enable |
| hst_stb | input | 1 | Host strobe |
| hst_rdt | output | 32 | Read data to host |
| hst_ack | output | 1 | Acknowledge to host |
| mem_adr | output | 32 | Memory port address |
| mem_dat | output | 32 | Memory port write data |
| mem_sel | output | 4 | Memory port byte select |
| mem_we | output | 1 | Memory port write enable |
| mem_stb | output | 1 | Memory port strobe |
| mem_rdt | input | 32 | Memory port read data |
| mem_ack | input | 1 | Memory port acknowledge |
| ext_adr | output | 32 | External port address |
| ext_dat | output | 32 | External port write data |
| ext_sel | output | 4 | External port byte select |
| ext_we | output | 1 | External port write enable |
| ext_stb | output | 1 | External port strobe |
| ext_rdt | input | 32 | External port read data |
| ext_ack | input | 1 | External port acknowledge |
| log_valid | output | 1 | One-cycle pulse for a captured log character |
| log_char | output | 8 | Captured log character |
| sim_done | output | 1 | Sticky end-of-simulation flag |

## Verification
The hardest case to reach is an access that is still waiting for its acknowledge while the live address has moved to the other region and the unselected port raises a stray acknowledge. A held target and a live decode differ only in that situation. The bench sets it up with random target latencies of zero to three cycles. Part way through a pending access it flips the address region and drives random acknowledges and read data on the port that was not chosen. A second instance with the simulation aid off receives the same special-address writes, so the two decode variants are compared under the same stimulus.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        TGT_MEM  = 2'd0,
        TGT_EXT  = 2'd1,
        TGT_LOG  = 2'd2,
        TGT_HALT = 2'd3
    } tgt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } st_e;

    typedef struct packed {
        st_e  st;
        tgt_e tgt;
    } route_s;

    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] chr;
        logic              done;
    } hook_s;

    function automatic logic is_local(tgt_e t);
        return (t == TGT_LOG) || (t == TGT_HALT);
    endfunction

endpackage

// File: rtl/spl_decode.sv
module spl_decode
    import splitter_pkg::*;
#(
    parameter int                 ADDR_W     = 32,
    parameter int                 REGION_W   = 2,
    parameter int                 MEM_REGION = 0,
    parameter bit                 SIM_EN     = 1'b0,
    parameter logic [ADDR_W-1:0]  LOG_ADDR   = 32'h8000_0000,
    parameter logic [ADDR_W-1:0]  HALT_ADDR  = 32'h9000_0000
) (
    input  logic [ADDR_W-1:0] adr,
    input  logic              we,
    output tgt_e              tgt
);

    localparam logic [REGION_W-1:0] MEM_CODE = REGION_W'(MEM_REGION);

    logic [REGION_W-1:0] region;
    logic                hit_log;
    logic                hit_halt;

    always_comb begin
        region   = adr[ADDR_W-1 -: REGION_W];
        hit_log  = SIM_EN && we && (adr == LOG_ADDR);
        hit_halt = SIM_EN && we && (adr == HALT_ADDR);
        if (hit_log)
            tgt = TGT_LOG;
        else if (hit_halt)
            tgt = TGT_HALT;
        else if (region == MEM_CODE)
            tgt = TGT_MEM;
        else
            tgt = TGT_EXT;
    end

endmodule

// File: rtl/spl_route.sv
module spl_route
    import splitter_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_stb,
    input  tgt_e              dec_tgt,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdt,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_rdt,
    output logic              mem_stb,
    output logic              ext_stb,
    output logic              hst_ack,
    output logic [DATA_W-1:0] hst_rdt,
    output logic              fire_log,
    output logic              fire_halt
);

    localparam route_s RST_VAL = '{st: ST_IDLE, tgt: TGT_MEM};

    route_s route_q, route_d;
    tgt_e   cur_tgt;
    logic   local_ack;

    always_comb begin
        cur_tgt   = (route_q.st == ST_WAIT) ? route_q.tgt : dec_tgt;
        mem_stb   = hst_stb && (cur_tgt == TGT_MEM);
        ext_stb   = hst_stb && (cur_tgt == TGT_EXT);
        local_ack = hst_stb && (route_q.st == ST_WAIT) && is_local(route_q.tgt);

        if (mem_stb)
            hst_ack = mem_ack;
        else if (ext_stb)
            hst_ack = ext_ack;
        else
            hst_ack = local_ack;

        case (cur_tgt)
            TGT_MEM: hst_rdt = mem_rdt;
            TGT_EXT: hst_rdt = ext_rdt;
            default: hst_rdt = '0;
        endcase

        fire_log  = hst_stb && (route_q.st == ST_IDLE) && (dec_tgt == TGT_LOG);
        fire_halt = hst_stb && (route_q.st == ST_IDLE) && (dec_tgt == TGT_HALT);

        route_d = route_q;
        case (route_q.st)
            ST_IDLE: begin
                if (hst_stb && (is_local(dec_tgt) || !hst_ack)) begin
                    route_d.st  = ST_WAIT;
                    route_d.tgt = dec_tgt;
                end
            end
            ST_WAIT: begin
                if (!hst_stb || hst_ack)
                    route_d.st = ST_IDLE;
            end
            default: route_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            route_q <= RST_VAL;
        else
            route_q <= route_d;
    end

    // R1 / R2: never both ports strobed
    assert_strobe_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        !(mem_stb && ext_stb));

    // R11: no acknowledge without a host strobe
    assert_ack_needs_stb_R11: assert property (@(posedge clk) disable iff (rst)
        hst_ack |-> hst_stb);

    // R5: a pending memory or external access keeps its port until ack or abort
    assert_mem_held_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_stb && !mem_ack) |=> (mem_stb || !hst_stb));

    assert_ext_held_R5: assert property (@(posedge clk) disable iff (rst)
        (ext_stb && !ext_ack) |=> (ext_stb || !hst_stb));

    // R6 / R7: a special write is answered on the following cycle
    assert_local_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (fire_log || fire_halt) |=> (hst_ack || !hst_stb));

endmodule

// File: rtl/spl_hooks.sv
module spl_hooks
    import splitter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_log,
    input  logic              fire_halt,
    input  logic [CHAR_W-1:0] wr_byte,
    output logic              log_valid,
    output logic [CHAR_W-1:0] log_char,
    output logic              sim_done
);

    localparam hook_s RST_VAL = '{valid: 1'b0, chr: '0, done: 1'b0};

    hook_s hook_q, hook_d;

    always_comb begin
        hook_d       = hook_q;
        hook_d.valid = fire_log;
        if (fire_log)
            hook_d.chr = wr_byte;
        if (fire_halt)
            hook_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            hook_q <= RST_VAL;
        else
            hook_q <= hook_d;
    end

    assign log_valid = hook_q.valid;
    assign log_char  = hook_q.chr;
    assign sim_done  = hook_q.done;

    // R6: the log strobe lasts a single cycle
    assert_log_single_R6: assert property (@(posedge clk) disable iff (rst)
        log_valid |=> !log_valid);

    // R7: the halt flag is sticky
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        sim_done |=> sim_done);

endmodule

// File: rtl/dbus_splitter.sv
module dbus_splitter
    import splitter_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter int                REGION_W   = 2,
    parameter int                MEM_REGION = 0,
    parameter bit                SIM_EN     = 1'b0,
    parameter logic [ADDR_W-1:0] LOG_ADDR   = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] HALT_ADDR  = 32'h9000_0000,
    localparam int               SEL_W      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] hst_adr,
    input  logic [DATA_W-1:0] hst_dat,
    input  logic [SEL_W-1:0]  hst_sel,
    input  logic              hst_we,
    input  logic              hst_stb,
    output logic [DATA_W-1:0] hst_rdt,
    output logic              hst_ack,
    output logic [ADDR_W-1:0] mem_adr,
    output logic [DATA_W-1:0] mem_dat,
    output logic [SEL_W-1:0]  mem_sel,
    output logic              mem_we,
    output logic              mem_stb,
    input  logic [DATA_W-1:0] mem_rdt,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] ext_adr,
    output logic [DATA_W-1:0] ext_dat,
    output logic [SEL_W-1:0]  ext_sel,
    output logic              ext_we,
    output logic              ext_stb,
    input  logic [DATA_W-1:0] ext_rdt,
    input  logic              ext_ack,
    output logic              log_valid,
    output logic [CHAR_W-1:0] log_char,
    output logic              sim_done
);

    tgt_e dec_tgt;
    logic fire_log;
    logic fire_halt;

    assign mem_adr = hst_adr;
    assign mem_dat = hst_dat;
    assign mem_sel = hst_sel;
    assign mem_we  = hst_we;
    assign ext_adr = hst_adr;
    assign ext_dat = hst_dat;
    assign ext_sel = hst_sel;
    assign ext_we  = hst_we;

    spl_decode #(
        .ADDR_W     (ADDR_W),
        .REGION_W   (REGION_W),
        .MEM_REGION (MEM_REGION),
        .SIM_EN     (SIM_EN),
        .LOG_ADDR   (LOG_ADDR),
        .HALT_ADDR  (HALT_ADDR)
    ) u_decode (
        .adr (hst_adr),
        .we  (hst_we),
        .tgt (dec_tgt)
    );

    spl_route #(
        .DATA_W (DATA_W)
    ) u_route (
        .clk       (clk),
        .rst       (rst),
        .hst_stb   (hst_stb),
        .dec_tgt   (dec_tgt),
        .mem_ack   (mem_ack),
        .mem_rdt   (mem_rdt),
        .ext_ack   (ext_ack),
        .ext_rdt   (ext_rdt),
        .mem_stb   (mem_stb),
        .ext_stb   (ext_stb),
        .hst_ack   (hst_ack),
        .hst_rdt   (hst_rdt),
        .fire_log  (fire_log),
        .fire_halt (fire_halt)
    );

    spl_hooks u_hooks (
        .clk       (clk),
        .rst       (rst),
        .fire_log  (fire_log),
        .fire_halt (fire_halt),
        .wr_byte   (hst_dat[CHAR_W-1:0]),
        .log_valid (log_valid),
        .log_char  (log_char),
        .sim_done  (sim_done)
    );

endmodule

// File: tb/tb_dbus_splitter.sv
module tb_dbus_splitter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] h_adr = '0, h_dat = '0;
    logic [3:0]  h_sel = '0;
    logic        h_we = 1'b0, h_stb = 1'b0;
    logic [31:0] m_rdt = '0, x_rdt = '0;
    logic        m_ack = 1'b0, x_ack = 1'b0;

    logic [31:0] s_rdt, s_madr, s_mdat, s_xadr, s_xdat;
    logic [3:0]  s_msel, s_xsel;
    logic        s_ack, s_mwe, s_mstb, s_xwe, s_xstb, s_lv, s_done;
    logic [7:0]  s_lc;
    logic [31:0] n_rdt, n_madr, n_mdat, n_xadr, n_xdat;
    logic [3:0]  n_msel, n_xsel;
    logic        n_ack, n_mwe, n_mstb, n_xwe, n_xstb, n_lv, n_done;
    logic [7:0]  n_lc;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;
    bit  watch_ns = 1'b0;

    localparam logic [31:0] A_LOG  = 32'h8000_0000;
    localparam logic [31:0] A_HALT = 32'h9000_0000;

    always #5 clk = ~clk;

    dbus_splitter #(.SIM_EN(1'b1)) dut (
        .clk(clk), .rst(rst),
        .hst_adr(h_adr), .hst_dat(h_dat), .hst_sel(h_sel), .hst_we(h_we), .hst_stb(h_stb),
        .hst_rdt(s_rdt), .hst_ack(s_ack),
        .mem_adr(s_madr), .mem_dat(s_mdat), .mem_sel(s_msel), .mem_we(s_mwe), .mem_stb(s_mstb),
        .mem_rdt(m_rdt), .mem_ack(m_ack),
        .ext_adr(s_xadr), .ext_dat(s_xdat), .ext_sel(s_xsel), .ext_we(s_xwe), .ext_stb(s_xstb),
        .ext_rdt(x_rdt), .ext_ack(x_ack),
        .log_valid(s_lv), .log_char(s_lc), .sim_done(s_done)
    );

    dbus_splitter #(.SIM_EN(1'b0)) dut_ns (
        .clk(clk), .rst(rst),
        .hst_adr(h_adr), .hst_dat(h_dat), .hst_sel(h_sel), .hst_we(h_we), .hst_stb(h_stb),
        .hst_rdt(n_rdt), .hst_ack(n_ack),
        .mem_adr(n_madr), .mem_dat(n_mdat), .mem_sel(n_msel), .mem_we(n_mwe), .mem_stb(n_mstb),
        .mem_rdt(m_rdt), .mem_ack(m_ack),
        .ext_adr(n_xadr), .ext_dat(n_xdat), .ext_sel(n_xsel), .ext_we(n_xwe), .ext_stb(n_xstb),
        .ext_rdt(x_rdt), .ext_ack(x_ack),
        .log_valid(n_lv), .log_char(n_lc), .sim_done(n_done)
    );

    // observed view: the simulation-mode instance or the plain one
    wire [31:0] v_rdt  = watch_ns ? n_rdt  : s_rdt;
    wire        v_ack  = watch_ns ? n_ack  : s_ack;
    wire        v_mstb = watch_ns ? n_mstb : s_mstb;
    wire        v_xstb = watch_ns ? n_xstb : s_xstb;
    wire        v_lv   = watch_ns ? n_lv   : s_lv;
    wire [7:0]  v_lc   = watch_ns ? n_lc   : s_lc;
    wire        v_done = watch_ns ? n_done : s_done;
    wire [73:0] v_mbus = watch_ns ? {n_madr, n_mdat, n_msel, n_mwe, 5'd0} : {s_madr, s_mdat, s_msel, s_mwe, 5'd0};
    wire [73:0] v_xbus = watch_ns ? {n_xadr, n_xdat, n_xsel, n_xwe, 5'd0} : {s_xadr, s_xdat, s_xsel, s_xwe, 5'd0};

    task automatic chk(input string tag, input logic [73:0] act, input logic [73:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // 0 memory, 1 external, 2 log, 3 halt
    function automatic int exp_tgt(input logic [31:0] a, input logic w, input bit sim);
        if (sim && w && a == A_LOG)  return 2;
        if (sim && w && a == A_HALT) return 3;
        if (a[31:30] == 2'b00)       return 0;
        return 1;
    endfunction

    task automatic txn(input logic [31:0] a, input logic [31:0] d, input logic [3:0] sl,
                       input logic w, input int lat, input bit jump);
        int  tgt;
        int  ack_at;
        bit  done;
        tgt    = exp_tgt(a, w, !watch_ns);
        ack_at = (tgt >= 2) ? 1 : lat;
        done   = 1'b0;
        @(negedge clk);
        h_adr = a; h_dat = d; h_sel = sl; h_we = w; h_stb = 1'b1;
        for (int k = 0; k < 8 && !done; k++) begin
            if (k > 0) @(negedge clk);
            if (jump && k == 1 && tgt < 2) h_adr = a ^ 32'hC000_0000;
            m_rdt = $urandom; x_rdt = $urandom;
            m_ack = (tgt == 0) ? (k == lat) : 1'($urandom % 2);
            x_ack = (tgt == 1) ? (k == lat) : 1'($urandom % 2);
            #1;
            chk((k > 0 && jump) ? "R5 mem strobe held" : "R1 mem strobe", 74'(v_mstb), 74'(tgt == 0));
            chk((k > 0 && jump) ? "R5 ext strobe held" : "R2 ext strobe", 74'(v_xstb), 74'(tgt == 1));
            chk("R3 memory port copy", v_mbus, {h_adr, h_dat, h_sel, h_we, 5'd0});
            chk("R3 external port copy", v_xbus, {h_adr, h_dat, h_sel, h_we, 5'd0});
            chk("R11 single ack", 74'(v_ack), 74'(k == ack_at));
            if (k == ack_at) begin
                done = 1'b1;
                if (tgt == 0) chk("R4 mem read data", 74'(v_rdt), 74'(m_rdt));
                if (tgt == 1) chk("R4 ext read data", 74'(v_rdt), 74'(x_rdt));
                if (tgt == 2) begin
                    chk("R6 log pulse", 74'(v_lv), 74'd1);
                    chk("R6 log char", 74'(v_lc), 74'(d[7:0]));
                end
                if (tgt == 3) chk("R7 halt flag", 74'(v_done), 74'd1);
            end else if (tgt >= 2) begin
                chk("R6 no early log pulse", 74'(v_lv), 74'd0);
            end
        end
        if (!done) chk("R11 ack never seen", 74'd0, 74'd1);
        @(negedge clk);
        h_stb = 1'b0; m_ack = 1'b0; x_ack = 1'b0;
        #1;
        chk("R11 no ack after strobe drop", 74'(v_ack), 74'd0);
        if (tgt == 2) chk("R6 log pulse one cycle", 74'(v_lv), 74'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; h_stb = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset mem strobe", 74'(v_mstb), 74'd0);
        chk("R10 reset ext strobe", 74'(v_xstb), 74'd0);
        chk("R10 reset ack", 74'(v_ack), 74'd0);
        chk("R10 reset log", 74'(v_lv), 74'd0);
        chk("R10 reset done", 74'(v_done), 74'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // directed region boundaries
        txn(32'h0000_0000, 32'h1111_2222, 4'hF, 1'b0, 0, 1'b0);
        txn(32'h3FFF_FFFC, 32'h3333_4444, 4'h3, 1'b1, 1, 1'b0);
        txn(32'h4000_0000, 32'h5555_6666, 4'h1, 1'b0, 2, 1'b0);
        txn(32'hFFFF_FFFC, 32'h7777_8888, 4'hC, 1'b1, 0, 1'b0);
        txn(32'h1234_5678, 32'h0, 4'hF, 1'b0, 3, 1'b1);
        txn(32'hC000_0010, 32'h0, 4'hF, 1'b0, 3, 1'b1);

        // random traffic
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            int          l;
            a = $urandom;
            l = int'($urandom % 4);
            txn(a, $urandom, 4'($urandom), 1'($urandom), l, (l > 0) && 1'($urandom));
        end

        // simulation hooks on the SIM_EN=1 instance
        txn(A_LOG, 32'hABCD_EF48, 4'h1, 1'b1, 0, 1'b0);
        txn(A_LOG, 32'h0000_0069, 4'h1, 1'b1, 2, 1'b0);
        txn(A_LOG, 32'h0, 4'hF, 1'b0, 1, 1'b0);   // R9 read goes outward
        chk("R9 read leaves log idle", 74'(v_lv), 74'd0);
        txn(A_HALT, 32'h0, 4'hF, 1'b0, 2, 1'b0);  // R9 read goes outward
        chk("R9 read leaves halt clear", 74'(v_done), 74'd0);
        txn(A_HALT, 32'h1, 4'hF, 1'b1, 0, 1'b0);
        txn(32'h0000_0100, 32'h0, 4'hF, 1'b0, 1, 1'b0);
        chk("R7 halt stays set", 74'(v_done), 74'd1);
        txn(A_LOG, 32'h0000_0021, 4'h1, 1'b1, 3, 1'b0);
        chk("R7 halt still set", 74'(v_done), 74'd1);
        do_reset();

        // same special writes seen by the SIM_EN=0 instance
        watch_ns = 1'b1;
        do_reset();
        txn(A_LOG, 32'h0000_0041, 4'h1, 1'b1, 1, 1'b0);
        chk("R8 no log without sim", 74'(v_lv), 74'd0);
        txn(A_HALT, 32'h1, 4'hF, 1'b1, 2, 1'b0);
        chk("R8 no halt without sim", 74'(v_done), 74'd0);
        for (int i = 0; i < 20; i++) begin
            txn($urandom, $urandom, 4'hF, 1'($urandom), int'($urandom % 4), 1'b0);
        end

        summary();
    end

endmodule